// File: doc/BRIEF.md
# Parallel Min-Plus Trellis Segment Combiner

This block turns the per-step branch metrics of a two-state trellis into segment metrics for longer and longer stretches of the trellis. A segment metric for start state `a` and end state `b` is the smallest path metric of any path that begins in `a` and ends in `b` across that stretch. All K step matrices arrive together in one wide word. A tree of min-plus products joins neighbouring segments level by level, so that after log2(K) levels the matrix for the whole block is known. The combining step works like the group propagate/generate merge in a tree adder. The tree has no feedback, so a register stage follows every level, and a new block can enter on every clock.

Besides the whole-block matrix, the block delivers the prefix matrices that start at step 0 and cover 2, 4, ... steps. Each prefix is delayed so that all prefixes of one block leave in the same cycle, tagged by one valid bit. A soft-output stage that combines these matrices with the reverse direction uses them.

Top module: `tsiso_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and every bit of `out_prefix` is 0.
- R2: `out_valid` is high exactly 3 clock edges after a cycle with `in_valid` high (default K=8), and low 3 edges after a cycle with `in_valid` low, including gaps between blocks.
- R3: A new block is accepted on every clock; blocks presented on consecutive cycles leave on consecutive cycles, in order, each with its own correct result.
- R4: Two adjacent segments combine as C[a][b] = min over the shared middle state m of (L[a][m] + R[m][b]); e.g. L row 0 = (1,2) with R column 0 = (2,2) gives C[0][0] = min(1+2, 2+2) = 3.
- R5: Every addition saturates: a sum above 255 yields 255, so an all-255 input block gives 255 in every output metric.
- R6: The minimum is an unsigned compare on 8-bit values: between 0x80 and 0x7F the result is 0x7F.
- R7: Output slot l of `out_prefix` holds the matrix from step 0 to step 2^(l+1); slot 2 (steps 0 to 8) is the whole-block matrix.
- R8: Input element (a,b) of step t sits at `in_bm[((t*2+a)*2+b)*8 +: 8]`; output element (a,b) of slot l sits at `out_prefix[((l*2+a)*2+b)*8 +: 8]`; a = start state, b = end state.
- R9: All prefix slots of one block appear in the same cycle as that block's `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_bm` as a block to process |
| in_bm | input | 256 | K=8 step matrices, 2x2 metrics of 8 bits each |
| out_valid | output | 1 | Marks `out_prefix` as the result of a block |
| out_prefix | output | 96 | Prefix matrices 0-2, 0-4, 0-8, one 32-bit matrix per slot |

## Verification
The assertions take for granted that `in_valid` is a clean 0 or 1 at every edge and is held low during reset, so the valid pipeline they model starts empty; they make no assumption about the metric values and check the all-zero and all-255 blocks whenever they occur. The row-minimum ordering between successive prefix slots holds for any metric values, because saturating addition never decreases an operand. The stimulus drives inputs only at the falling edge, keeps `in_valid` low through reset, and mixes random metric blocks with hand-built ones that hit the saturation limit, the unsigned compare boundary and the worked combining case.

// File: rtl/tsiso_pkg.sv
package tsiso_pkg;

    // Bit offset of element (a,b) within one NS x NS matrix of W-bit metrics.
    function automatic int unsigned cell_ofs(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned ns,
                                             input int unsigned w);
        return (a * ns + b) * w;
    endfunction

endpackage

// File: rtl/tsiso_minplus.sv
module tsiso_minplus #(
    parameter int NS = 2,
    parameter int W  = 8
) (
    input  logic [NS*NS*W-1:0] lhs,
    input  logic [NS*NS*W-1:0] rhs,
    output logic [NS*NS*W-1:0] prod
);
    import tsiso_pkg::*;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] x,
                                             input logic [W-1:0] y);
        logic [W:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[W] ? {W{1'b1}} : s[W-1:0];
    endfunction

    always_comb begin
        logic [W-1:0] best;
        logic [W-1:0] cand;
        prod = '0;
        for (int a = 0; a < NS; a++) begin
            for (int b = 0; b < NS; b++) begin
                best = {W{1'b1}};
                for (int m = 0; m < NS; m++) begin
                    cand = sat_add(lhs[cell_ofs(a, m, NS, W) +: W],
                                   rhs[cell_ofs(m, b, NS, W) +: W]);
                    if (cand < best) best = cand;
                end
                prod[cell_ofs(a, b, NS, W) +: W] = best;
            end
        end
    end

endmodule

// File: rtl/tsiso_level.sv
module tsiso_level #(
    parameter int NSEG = 8,
    parameter int NS   = 2,
    parameter int W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_v,
    input  logic [NSEG*NS*NS*W-1:0]        seg_in,
    output logic                           out_v,
    output logic [(NSEG/2)*NS*NS*W-1:0]    seg_out
);
    localparam int MW   = NS * NS * W;
    localparam int NOUT = NSEG / 2;

    logic [NOUT*MW-1:0] merged;

    for (genvar p = 0; p < NOUT; p++) begin : g_pair
        tsiso_minplus #(.NS(NS), .W(W)) u_mp (
            .lhs  (seg_in[(2*p)*MW +: MW]),
            .rhs  (seg_in[(2*p+1)*MW +: MW]),
            .prod (merged[p*MW +: MW])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            seg_out <= '0;
        end else begin
            out_v   <= in_v;
            seg_out <= merged;
        end
    end

endmodule

// File: rtl/tsiso_align.sv
module tsiso_align #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    if (DEPTH == 0) begin : g_pass
        assign dout = din;
    end else begin : g_shift
        logic [WIDTH-1:0] sr [DEPTH];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
            end else begin
                sr[0] <= din;
                for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
            end
        end
        assign dout = sr[DEPTH-1];
    end

endmodule

// File: rtl/tsiso_top.sv
module tsiso_top #(
    parameter int K  = 8,
    parameter int NS = 2,
    parameter int W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [K*NS*NS*W-1:0]                in_bm,
    output logic                                out_valid,
    output logic [$clog2(K)*NS*NS*W-1:0]        out_prefix
);
    localparam int MW   = NS * NS * W;
    localparam int LVLS = $clog2(K);

    for (genvar l = 0; l < LVLS; l++) begin : lv
        localparam int NIN  = K >> l;
        localparam int NOUT = NIN / 2;

        logic [NIN*MW-1:0]  d;
        logic               dv;
        logic [NOUT*MW-1:0] q;
        logic               qv;

        if (l == 0) begin : g_first
            assign d  = in_bm;
            assign dv = in_valid;
        end else begin : g_next
            assign d  = lv[l-1].q;
            assign dv = lv[l-1].qv;
        end

        tsiso_level #(.NSEG(NIN), .NS(NS), .W(W)) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (dv),
            .seg_in  (d),
            .out_v   (qv),
            .seg_out (q)
        );

        // Segment 0 of this level is the prefix 0 .. 2^(l+1); hold it
        // until the last level has finished with the same block.
        tsiso_align #(.DEPTH(LVLS-1-l), .WIDTH(MW)) u_align (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (q[MW-1:0]),
            .dout  (out_prefix[l*MW +: MW])
        );
    end

    assign out_valid = lv[LVLS-1].qv;

endmodule

// File: rtl/tsiso_chk.sv
module tsiso_chk #(
    parameter int K  = 8,
    parameter int NS = 2,
    parameter int W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [K*NS*NS*W-1:0]         in_bm,
    input logic                         out_valid,
    input logic [$clog2(K)*NS*NS*W-1:0] out_prefix
);
    localparam int MW   = NS * NS * W;
    localparam int LVLS = $clog2(K);

    logic [LVLS-1:0] vpipe, zpipe, fpipe;
    logic            mono_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            zpipe <= '0;
            fpipe <= '0;
        end else begin
            vpipe <= (vpipe << 1) | LVLS'(in_valid);
            zpipe <= (zpipe << 1) | LVLS'(in_valid && (in_bm == '0));
            fpipe <= (fpipe << 1) | LVLS'(in_valid && (&in_bm));
        end
    end

    always_comb begin
        logic [W-1:0] mprev;
        logic [W-1:0] mcur;
        mono_ok = 1'b1;
        for (int l = 1; l < LVLS; l++) begin
            for (int a = 0; a < NS; a++) begin
                mprev = {W{1'b1}};
                mcur  = {W{1'b1}};
                for (int b = 0; b < NS; b++) begin
                    if (out_prefix[((l-1)*NS*NS + a*NS + b)*W +: W] < mprev)
                        mprev = out_prefix[((l-1)*NS*NS + a*NS + b)*W +: W];
                    if (out_prefix[(l*NS*NS + a*NS + b)*W +: W] < mcur)
                        mcur = out_prefix[(l*NS*NS + a*NS + b)*W +: W];
                end
                if (mcur < mprev) mono_ok = 1'b0;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[LVLS-1]); // R2

    AST_ZERO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zpipe[LVLS-1]) |-> (out_prefix == '0)); // R4

    AST_SAT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fpipe[LVLS-1]) |-> (&out_prefix)); // R5

    AST_PREFIX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mono_ok); // R7

endmodule

bind tsiso_top tsiso_chk #(.K(K), .NS(NS), .W(W)) u_chk (.*);

// File: tb/tb_tsiso_top.sv
module tb_tsiso_top;
    localparam int K  = 8;
    localparam int NS = 2;
    localparam int W  = 8;
    localparam int IW = K * NS * NS * W;
    localparam int OW = 3 * NS * NS * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [IW-1:0] in_bm;
    logic          out_valid;
    logic [OW-1:0] out_prefix;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tsiso_top #(.K(K), .NS(NS), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bm(in_bm),
        .out_valid(out_valid), .out_prefix(out_prefix)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int el(input logic [IW-1:0] v, input int t, input int a, input int b);
        return int'(v[((t*2+a)*2+b)*8 +: 8]);
    endfunction

    // Sequential left-to-right reference: prefix = step0 (x) step1 (x) ...
    function automatic logic [OW-1:0] model(input logic [IW-1:0] v);
        int p[2][2];
        int n[2][2];
        logic [OW-1:0] e = '0;
        int slot;
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++) p[a][b] = el(v, 0, a, b);
        for (int t = 1; t < K; t++) begin
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 2; b++) begin
                    n[a][b] = 255;
                    for (int m = 0; m < 2; m++) begin
                        int s = p[a][m] + el(v, t, m, b);
                        if (s > 255) s = 255;
                        if (s < n[a][b]) n[a][b] = s;
                    end
                end
            p = n;
            slot = (t == 1) ? 0 : (t == 3) ? 1 : (t == 7) ? 2 : -1;
            if (slot >= 0)
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2; b++)
                        e[((slot*2+a)*2+b)*8 +: 8] = 8'(p[a][b]);
        end
        return e;
    endfunction

    function automatic logic [IW-1:0] rand_block();
        logic [IW-1:0] v;
        for (int i = 0; i < IW/8; i++) v[i*8 +: 8] = 8'($urandom_range(0, 255));
        return v;
    endfunction

    // Drives blocks on consecutive cycles (valid per mask bit) and checks
    // every result 3 edges later. Starts and ends at a falling edge.
    task automatic stream(input int n, input logic [IW-1:0] blk [8],
                          input logic [7:0] mask, input string req,
                          output logic [OW-1:0] last_out);
        for (int cyc = 0; cyc < n + 3; cyc++) begin
            if (cyc >= 3) begin
                check(out_valid == mask[cyc-3], req, "out_valid",
                      OW'(out_valid), OW'(mask[cyc-3]));
                if (mask[cyc-3]) begin
                    check(out_prefix == model(blk[cyc-3]), req, "prefix slots",
                          out_prefix, model(blk[cyc-3]));
                    last_out = out_prefix;
                end
            end
            if (cyc < n) begin
                in_bm    = blk[cyc];
                in_valid = mask[cyc];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1", "out_valid after reset", OW'(out_valid), '0);
        check(out_prefix == '0, "R1", "out_prefix after reset", out_prefix, '0);
    endtask

    task automatic t_latency();
        logic [IW-1:0] v = rand_block();
        in_bm = v; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check(out_valid == 1'b0, "R2", "valid after 1 edge", OW'(out_valid), '0);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid after 2 edges", OW'(out_valid), '0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2", "valid after 3 edges", OW'(out_valid), OW'(1));
        check(out_prefix == model(v), "R9", "all slots aligned", out_prefix, model(v));
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "valid after 4 edges", OW'(out_valid), '0);
    endtask

    task automatic t_worked();
        logic [IW-1:0] blk [8];
        logic [OW-1:0] o;
        logic [IW-1:0] v = '0;
        // R8 layout: step 0 row 0 = (1,2); step 1 column 0 = (2,2)
        v[((0*2+0)*2+0)*8 +: 8] = 8'd1;
        v[((0*2+0)*2+1)*8 +: 8] = 8'd2;
        v[((1*2+0)*2+0)*8 +: 8] = 8'd2;
        v[((1*2+1)*2+0)*8 +: 8] = 8'd2;
        v[((0*2+1)*2+1)*8 +: 8] = 8'd40;
        v[((5*2+1)*2+0)*8 +: 8] = 8'd9;
        blk[0] = v;
        for (int i = 1; i < 8; i++) blk[i] = '0;
        o = '0;
        stream(1, blk, 8'h01, "R8", o);
        check(o[7:0] == 8'd3, "R4", "worked case min(1+2,2+2)", OW'(o[7:0]), OW'(3));
    endtask

    task automatic t_stream();
        logic [IW-1:0] blk [8];
        logic [OW-1:0] o;
        for (int i = 0; i < 8; i++) blk[i] = rand_block();
        stream(8, blk, 8'hFF, "R3", o);
        check(o[2*32 +: 32] == model(blk[7])[2*32 +: 32], "R7",
              "whole-block slot of last block", OW'(o[2*32 +: 32]),
              OW'(model(blk[7])[2*32 +: 32]));
    endtask

    task automatic t_gap();
        logic [IW-1:0] blk [8];
        logic [OW-1:0] o;
        for (int i = 0; i < 8; i++) blk[i] = rand_block();
        stream(6, blk, 8'b0010_1101, "R2", o);
    endtask

    task automatic t_saturate();
        logic [IW-1:0] blk [8];
        logic [OW-1:0] o;
        for (int i = 0; i < 8; i++) blk[i] = '0;
        for (int i = 0; i < IW/8; i++) blk[0][i*8 +: 8] = 8'd200;
        blk[1] = '1;
        o = '0;
        stream(2, blk, 8'h03, "R5", o);
        check(o == '1, "R5", "all-255 block", o, '1);
        check(model(blk[0]) == {3{32'hFFFF_FFFF}}, "R5", "200+200 clamps",
              model(blk[0]), '1);
    endtask

    task automatic t_unsigned();
        logic [IW-1:0] blk [8];
        logic [OW-1:0] o;
        logic [IW-1:0] v = '0;
        v[((0*2+0)*2+0)*8 +: 8] = 8'h80;
        v[((0*2+0)*2+1)*8 +: 8] = 8'h10;
        v[((1*2+1)*2+0)*8 +: 8] = 8'h6F;
        for (int i = 0; i < 8; i++) blk[i] = '0;
        blk[0] = v;
        o = '0;
        stream(1, blk, 8'h01, "R6", o);
        check(o[7:0] == 8'h7F, "R6", "unsigned min 0x80 vs 0x7F",
              OW'(o[7:0]), OW'(8'h7F));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_bm = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", OW'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_worked();
        t_stream();
        t_gap();
        t_saturate();
        t_unsigned();
        finish_run();
    end

endmodule